// File: doc/BRIEF.md
# Interrupt Aggregation and Core Gating Controller

This block gathers interrupt requests from a set of peripheral engines into one system-level pending register. It then decides, from the processor core's status bits, whether the core may take an interrupt now. Each source owns one pending bit, which latches on a request and stays set until software acknowledges it. A mask register chooses which pending bits count. Together, the pending and mask registers drive one shared hardware line in the core's cause field. The gating stage combines that line with the other cause lines, the core's interrupt-mask field and its enable and level bits. The result is a single registered take-interrupt request.

Software reaches the block over a small synchronous register bus. Pending bits are cleared by writing ones to the pending address. The mask uses separate set and clear fields in one write word, so no read-modify-write sequence is needed. A read returns its data on the clock edge after the read is presented.

Top module: `irq_agg_top`

## Requirements
- R1: While reset is held, at the following edge the pending register, the mask register, the cause line output, the take-interrupt output and the read data are all zero.
- R2: A high request on source i sets pending bit i at the next clock edge. The bit stays set after the request drops, until it is acknowledged.
- R3: A write to address 0 clears, one cycle later, each pending bit whose data bit is 1. Bits written 0 are untouched. A request arriving in the same cycle as its acknowledge leaves the bit set.
- R4: A write to address 1 sets mask bits given by data bits [NUM_SRC-1:0] and clears mask bits given by data bits [DATA_W/2+NUM_SRC-1:DATA_W/2]. When both the set and the clear bit for a source are given, the clear wins.
- R5: The cause line output equals, one cycle later, the OR of (pending AND mask).
- R6: The take-interrupt output is 0 in the cycle after the global enable input was low.
- R7: The take-interrupt output is 0 in the cycle after either the exception-level input or the error-level input was high.
- R8: Otherwise the take-interrupt output is 1 in the cycle after the 8-bit interrupt-mask field ANDed with the 8-bit cause field is nonzero. The cause field is the external cause lines with bit IP_LINE (default 2) replaced by the next value of the cause line. The external bit at that position has no effect.
- R9: A read returns, at the next edge, pending (address 0) or mask (address 1) zero-extended, and 0 for any other address. Read data holds when no read occurs. Writes to addresses other than 0 and 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Per-source request lines (bit 0 signal engine, bit 1 display engine, bit 2 audio) |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| st_ie | input | 1 | Core global interrupt enable |
| st_exl | input | 1 | Core exception-level bit |
| st_erl | input | 1 | Core error-level bit |
| st_im | input | 8 | Core interrupt-mask field |
| cause_ip_ext | input | 8 | Other cause lines from outside the block |
| pending_o | output | NUM_SRC | Pending register |
| ip_line_o | output | 1 | Shared cause line driven by this block |
| take_irq_o | output | 1 | Registered take-interrupt request to the core |

## Verification
The bench builds the block with three sources, a 32-bit data word, a 4-bit address and the cause line at position 2. With three sources, every pending and mask pattern can occur. Random addresses over 0..15 hit the two mapped registers and the unmapped space about equally. Directed cases cover two races: a request racing its own acknowledge, and one write carrying both a set and a clear for the same source. Random status values then mix the enable, exception-level and error-level gating with external cause lines, including the external bit at the replaced position.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int IP_W = 8;

    typedef struct packed {
        logic            ie;
        logic            exl;
        logic            erl;
        logic [IP_W-1:0] im;
    } core_status_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ACK  = 2'd1,
        OP_MASK = 2'd2,
        OP_READ = 2'd3
    } bus_op_e;

    // Core accepts interrupts only when enabled and not at exception or error level.
    function automatic logic gate_open(core_status_t st);
        return st.ie && !st.exl && !st.erl;
    endfunction

endpackage

// File: rtl/irq_regif.sv
module irq_regif
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 3,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic [NUM_SRC-1:0] ack_o,
    output logic [NUM_SRC-1:0] set_o,
    output logic [NUM_SRC-1:0] clr_o,
    output logic [DATA_W-1:0]  rdata_o
);
    localparam int CLR_OFS = DATA_W / 2;
    localparam logic [ADDR_W-1:0] PEND_ADDR = '0;
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(1);

    bus_op_e           op;
    logic [DATA_W-1:0] rd_val;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata;

    always_comb begin
        op = OP_NONE;
        if (bus_en) begin
            if (!bus_we)                    op = OP_READ;
            else if (bus_addr == PEND_ADDR) op = OP_ACK;
            else if (bus_addr == MASK_ADDR) op = OP_MASK;
        end
    end

    assign ack_o = (op == OP_ACK)  ? bus_wdata[NUM_SRC-1:0]       : '0;
    assign set_o = (op == OP_MASK) ? bus_wdata[NUM_SRC-1:0]       : '0;
    assign clr_o = (op == OP_MASK) ? bus_wdata[CLR_OFS +: NUM_SRC] : '0;

    always_comb begin
        rd_val = '0;
        if (bus_addr == PEND_ADDR)      rd_val[NUM_SRC-1:0] = pend_i;
        else if (bus_addr == MASK_ADDR) rd_val[NUM_SRC-1:0] = mask_i;
    end

    always_ff @(posedge clk) begin
        if (rst)                 rdata_o <= '0;
        else if (op == OP_READ)  rdata_o <= rd_val;
    end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] ack_i,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] mask_o
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        // Pending: a fresh request outranks its own acknowledge.
        always_ff @(posedge clk) begin
            if (rst) pend_o[i] <= 1'b0;
            else     pend_o[i] <= (pend_o[i] && !ack_i[i]) || req_i[i];
        end
        // Mask: clear outranks set.
        always_ff @(posedge clk) begin
            if (rst)           mask_o[i] <= 1'b0;
            else if (clr_i[i]) mask_o[i] <= 1'b0;
            else if (set_i[i]) mask_o[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 3,
    parameter int IP_LINE = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  core_status_t       st_i,
    input  logic [IP_W-1:0]    ext_i,
    output logic               line_o,
    output logic               take_o
);
    logic            line_next;
    logic [IP_W-1:0] field;
    logic            take_next;
    logic            unused_ext;

    assign unused_ext = ext_i[IP_LINE];
    assign line_next  = |(pend_i & mask_i);

    always_comb begin
        field          = ext_i;
        field[IP_LINE] = line_next;
    end

    assign take_next = gate_open(st_i) && (|(st_i.im & field));

    always_ff @(posedge clk) begin
        if (rst) begin
            line_o <= 1'b0;
            take_o <= 1'b0;
        end else begin
            line_o <= line_next;
            take_o <= take_next;
        end
    end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 3,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int IP_LINE = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               st_ie,
    input  logic               st_exl,
    input  logic               st_erl,
    input  logic [IP_W-1:0]    st_im,
    input  logic [IP_W-1:0]    cause_ip_ext,
    output logic [NUM_SRC-1:0] pending_o,
    output logic               ip_line_o,
    output logic               take_irq_o
);
    logic [NUM_SRC-1:0] ack_v, set_v, clr_v, mask_q;
    core_status_t       status;

    assign status = '{ie: st_ie, exl: st_exl, erl: st_erl, im: st_im};

    irq_regif #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .pend_i(pending_o), .mask_i(mask_q),
        .ack_o(ack_v), .set_o(set_v), .clr_o(clr_v), .rdata_o(bus_rdata)
    );

    irq_pend_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk(clk), .rst(rst), .req_i(src_req), .ack_i(ack_v),
        .set_i(set_v), .clr_i(clr_v), .pend_o(pending_o), .mask_o(mask_q)
    );

    irq_gate #(.NUM_SRC(NUM_SRC), .IP_LINE(IP_LINE)) u_gate (
        .clk(clk), .rst(rst), .pend_i(pending_o), .mask_i(mask_q),
        .st_i(status), .ext_i(cause_ip_ext),
        .line_o(ip_line_o), .take_o(take_irq_o)
    );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
    parameter int NUM_SRC = 3,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] src_req,
    input logic               bus_en,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [NUM_SRC-1:0] pending_o,
    input logic [NUM_SRC-1:0] mask_q,
    input logic               ip_line_o,
    input logic               take_irq_o,
    input logic               st_ie,
    input logic               st_exl,
    input logic               st_erl
);
    localparam int CLR_OFS = DATA_W / 2;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (pending_o == '0 && mask_q == '0 && !ip_line_o && !take_irq_o));

    // R2
    pend_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (|src_req) |=> ((pending_o & $past(src_req)) == $past(src_req)));

    // R3
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_addr == '0)
        |=> ((pending_o & $past(bus_wdata[NUM_SRC-1:0] & ~src_req)) == '0));

    // R4
    mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_addr == ADDR_W'(1))
        |=> ((mask_q & $past(bus_wdata[CLR_OFS +: NUM_SRC])) == '0));

    // R5
    line_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ip_line_o == $past(|(pending_o & mask_q))));

    // R6
    take_enable_chk: assert property (@(posedge clk) disable iff (rst)
        !st_ie |=> !take_irq_o);

    // R7
    take_level_chk: assert property (@(posedge clk) disable iff (rst)
        (st_exl || st_erl) |=> !take_irq_o);
endmodule

bind irq_agg_top irq_agg_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .src_req(src_req), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pending_o(pending_o),
    .mask_q(mask_q), .ip_line_o(ip_line_o), .take_irq_o(take_irq_o),
    .st_ie(st_ie), .st_exl(st_exl), .st_erl(st_erl)
);

// File: tb/tb_irq_agg_top.sv
`timescale 1ns/1ps
module tb_irq_agg_top;
    localparam int NS  = 3;
    localparam int AW  = 4;
    localparam int DW  = 32;
    localparam int IPL = 2;
    localparam int CLR = DW / 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst;
    logic [NS-1:0] src_req;
    logic          bus_en, bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          st_ie, st_exl, st_erl;
    logic [7:0]    st_im, cause_ip_ext;
    logic [NS-1:0] pending;
    logic          ip_line, take;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    irq_agg_top #(.NUM_SRC(NS), .ADDR_W(AW), .DATA_W(DW), .IP_LINE(IPL)) dut (
        .clk(clk), .rst(rst), .src_req(src_req), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .st_ie(st_ie), .st_exl(st_exl), .st_erl(st_erl), .st_im(st_im),
        .cause_ip_ext(cause_ip_ext), .pending_o(pending), .ip_line_o(ip_line),
        .take_irq_o(take)
    );

    // Behavioural reference, advanced on every rising edge.
    logic [NS-1:0] m_pend, m_mask;
    logic          m_line, m_take;
    logic [DW-1:0] m_rd;

    always @(posedge clk) begin : ref_model
        logic [NS-1:0] p0, k0;
        logic [7:0]    fld;
        logic          hit;
        p0 = m_pend;
        k0 = m_mask;
        if (rst) begin
            m_pend = '0; m_mask = '0; m_line = 1'b0; m_take = 1'b0; m_rd = '0;
        end else begin
            hit      = |(p0 & k0);
            m_line   = hit;
            fld      = cause_ip_ext;
            fld[IPL] = hit;
            m_take   = st_ie && !st_exl && !st_erl && (|(st_im & fld));
            if (bus_en && bus_we && bus_addr == 0)
                m_pend = p0 & ~bus_wdata[NS-1:0];
            m_pend = m_pend | src_req;
            if (bus_en && bus_we && bus_addr == 1)
                m_mask = (k0 | bus_wdata[NS-1:0]) & ~bus_wdata[CLR +: NS];
            if (bus_en && !bus_we)
                m_rd = (bus_addr == 0) ? DW'(p0) : (bus_addr == 1) ? DW'(k0) : '0;
        end
    end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmp_all();
        chk("R2/R3 pending vs model", DW'(pending), DW'(m_pend));
        chk("R5 cause line vs model", DW'(ip_line), DW'(m_line));
        chk("R8 take vs model", DW'(take), DW'(m_take));
        chk("R9 read data vs model", bus_rdata, m_rd);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        cmp_all();
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        cyc();
        bus_en = 1'b0;
    endtask

    initial begin : watchdog
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        rst = 1'b1; src_req = '0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0;
        bus_wdata = '0; st_ie = 1'b0; st_exl = 1'b0; st_erl = 1'b0;
        st_im = '0; cause_ip_ext = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pending", DW'(pending), '0);
        chk("R1 cause line", DW'(ip_line), '0);
        chk("R1 take", DW'(take), '0);
        chk("R1 rdata", bus_rdata, '0);
        rst = 1'b0;
        cyc();

        // R2 latch and hold
        src_req = 3'b100; cyc();
        src_req = '0; cyc(); cyc();
        chk("R2 held after request drops", DW'(pending), DW'(3'b100));

        // R4 set 111 with clear of bit 1 in the same write -> 101
        wr(4'd1, 32'h0002_0007);
        rd(4'd1);
        chk("R4 clear wins over set", bus_rdata, 32'd5);

        // R5 line up from pending 100 & mask 101
        chk("R5 line high", DW'(ip_line), 1);

        // R8 take with enable and matching mask bit at position 2
        st_ie = 1'b1; st_im = 8'h04; cyc();
        chk("R8 take asserted", DW'(take), 1);

        // R7 level bits block
        st_exl = 1'b1; cyc();
        chk("R7 exception level blocks", DW'(take), 0);
        st_exl = 1'b0; st_erl = 1'b1; cyc();
        chk("R7 error level blocks", DW'(take), 0);
        st_erl = 1'b0; cyc();
        chk("R8 take restored", DW'(take), 1);

        // R6 enable low blocks
        st_ie = 1'b0; cyc();
        chk("R6 enable low blocks", DW'(take), 0);
        st_ie = 1'b1;

        // R3 request in same cycle as acknowledge wins
        src_req = 3'b100;
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = 32'd4;
        cyc();
        src_req = '0; bus_en = 1'b0; bus_we = 1'b0;
        chk("R3 request beats ack", DW'(pending), 4);
        wr(4'd0, 32'd4);
        chk("R3 ack clears", DW'(pending), 0);
        cyc();
        chk("R5 line drops", DW'(ip_line), 0);

        // R8 other cause line, and replaced external bit has no effect
        cause_ip_ext = 8'h80; st_im = 8'h80; cyc();
        chk("R8 external line", DW'(take), 1);
        cause_ip_ext = 8'h04; st_im = 8'h04; cyc(); cyc();
        chk("R8 external bit at line position ignored", DW'(take), 0);

        // R9 unmapped write ignored, unmapped read zero, hold when idle
        wr(4'd5, 32'hFFFF_FFFF);
        rd(4'd1);
        chk("R9 mask unchanged by unmapped write", bus_rdata, 32'd5);
        rd(4'd7);
        chk("R9 unmapped read zero", bus_rdata, 32'd0);
        cyc();
        chk("R9 read data holds", bus_rdata, 32'd0);

        // Random phase against the reference model
        for (int n = 0; n < 4000; n++) begin
            src_req      = ($urandom % 4 == 0) ? NS'($urandom) : '0;
            bus_en       = ($urandom % 3 == 0);
            bus_we       = $urandom % 2;
            bus_addr     = ($urandom % 2) ? AW'($urandom % 3) : AW'($urandom);
            bus_wdata    = $urandom;
            st_ie        = ($urandom % 4 != 0);
            st_exl       = ($urandom % 8 == 0);
            st_erl       = ($urandom % 8 == 0);
            st_im        = 8'($urandom);
            cause_ip_ext = ($urandom % 2) ? 8'($urandom) : 8'h00;
            cyc();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule